// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block decides whether conditional stores succeed. Several hardware contexts share one memory, and each context is named by a CPU number together with a thread number. A load-reserved read records the requesting context and the address granule it touched. A plain or conditional store to a recorded granule removes every record that holds that granule, whichever context made it. A store-conditional succeeds only when the requesting context still owns a record for the granule it targets.

The block sits beside the memory datapath. It stores no data and moves none. Each request is one strobe carrying a command, a physical address and the context. One cycle later the block returns a write permission and a one-bit conditional result. The memory must use the write permission to gate its write, so a failed conditional store never reaches the array. The table has a parameterised number of entries. When it is full, a new context evicts the entry that has been valid the longest.

Top module: `rsv_monitor`

## Requirements
- R1: After reset no reservation exists. While reset is held, rsp_vld, rsp_wr_ok and rsp_sc_ok are 0. The first store-conditional after reset fails (rsp_wr_ok=0, rsp_sc_ok=0).
- R2: A context owns at most one reservation. A second load-reserved from the same context moves that reservation to the new granule. A store-conditional to the old granule then fails, and one to the new granule succeeds.
- R3: Addresses are compared as granules of GRAN_BYTES bytes, with a default of 8. Address bits [2:0] are ignored by default, so 0x100 and 0x104 match. Neighbouring granules such as 0x900 and 0x908 do not match.
- R4: Several contexts may reserve the same granule at once. Any store, plain or conditional, to that granule removes the reservations of every context on it.
- R5: A plain store always returns rsp_wr_ok=1 and rsp_sc_ok=0, whatever the table holds.
- R6: A store-conditional succeeds only if the requesting context (CPU number and thread number both equal) holds a reservation on the target granule. It then returns rsp_sc_ok=1 and rsp_wr_ok=1. Otherwise both outputs are 0.
- R7: A failing store-conditional still removes other contexts' reservations on its granule.
- R8: If the table is full, a load-reserved from a context without an entry replaces the entry that has been valid the longest. A free entry is always used before any eviction.
- R9: The response appears on the clock edge that follows the request strobe (rsp_vld=1 for one cycle). A request issued in the next cycle already sees the table as updated by the previous request.
- R10: Command encoding on req_cmd is 0 = plain read, 1 = load-reserved, 2 = plain store, 3 = store-conditional. A plain read leaves the table unchanged. A plain read and a load-reserved both return rsp_wr_ok=0 and rsp_sc_ok=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| req_cmd | input | 2 | Command: 0 read, 1 load-reserved, 2 store, 3 store-conditional |
| req_addr | input | ADDR_W | Physical byte address |
| req_cpu | input | CPU_W | CPU number of the requester |
| req_thr | input | THR_W | Thread number of the requester |
| rsp_vld | output | 1 | Response valid, one cycle after req_vld |
| rsp_wr_ok | output | 1 | Memory write is permitted |
| rsp_sc_ok | output | 1 | Store-conditional result: 1 success, 0 failure |

## Verification
Two functions can fall in the same cycle: a store-conditional passes for its own context, and on the same edge it clears the entries of every other context on that granule. The bench provokes this by letting two contexts reserve one granule. One of them then issues a conditional store, followed at once by a conditional store from the other. The first store must succeed and the second must fail. The same edge is also where a full table evicts its oldest entry while it takes the new one. The bench fills the table, adds a fifth context, and then probes every original context to check that only the oldest one was evicted.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    CMD_READ = 2'd0,
    CMD_LR   = 2'd1,
    CMD_ST   = 2'd2,
    CMD_SC   = 2'd3
  } rsv_cmd_e;
endpackage

// File: rtl/rsv_slot.sv
module rsv_slot #(
  parameter int CTX_W  = 3,
  parameter int GRAN_W = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTX_W-1:0]  wr_ctx,
  input  logic [GRAN_W-1:0] wr_gran,
  input  logic              clr,
  output logic              vld_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic [GRAN_W-1:0] gran_o
);
  logic              vld_q;
  logic [CTX_W-1:0]  ctx_q;
  logic [GRAN_W-1:0] gran_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      ctx_q  <= '0;
      gran_q <= '0;
    end else if (wr_en) begin
      vld_q  <= 1'b1;
      ctx_q  <= wr_ctx;
      gran_q <= wr_gran;
    end else if (clr) begin
      vld_q  <= 1'b0;
    end
  end

  assign vld_o  = vld_q;
  assign ctx_o  = ctx_q;
  assign gran_o = gran_q;

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr && !wr_en) |=> !vld_q); // R4
  AST_RESET_EMPTY: assert property (@(posedge clk)
    $past(rst) |-> !vld_q); // R1
endmodule

// File: rtl/rsv_age.sv
module rsv_age #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] alloc_oh,
  input  logic [N-1:0] vld,
  output logic [N-1:0] oldest_oh
);
  // older_q[i][j] set: entry i was allocated before entry j
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          older_q[i][j] <= (i < j);
    end else begin
      for (int k = 0; k < N; k++) begin
        if (alloc_oh[k]) begin
          for (int j = 0; j < N; j++) begin
            if (j != k) begin
              older_q[j][k] <= 1'b1;
              older_q[k][j] <= 1'b0;
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      oldest_oh[i] = vld[i];
      for (int j = 0; j < N; j++)
        if (j != i && vld[j] && older_q[j][i])
          oldest_oh[i] = 1'b0;
    end
  end

  AST_VICTIM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(oldest_oh)); // R8
  AST_VICTIM_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (&vld) |-> ($countones(oldest_oh) == 1)); // R8
  AST_ALLOC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alloc_oh)); // R8
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int N_ENTRIES  = 4,
  parameter int ADDR_W     = 32,
  parameter int GRAN_BYTES = 8,
  parameter int CPU_W      = 2,
  parameter int THR_W      = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [THR_W-1:0]  req_thr,
  output logic              rsp_vld,
  output logic              rsp_wr_ok,
  output logic              rsp_sc_ok
);
  localparam int GRAN_LSB = $clog2(GRAN_BYTES);
  localparam int GRAN_W   = ADDR_W - GRAN_LSB;
  localparam int CTX_W    = CPU_W + THR_W;

  rsv_cmd_e          cmd;
  logic [GRAN_W-1:0] req_gran;
  logic [CTX_W-1:0]  req_ctx;
  logic              unused_low_bits;

  assign cmd             = rsv_cmd_e'(req_cmd);
  assign req_gran        = req_addr[ADDR_W-1:GRAN_LSB];
  assign req_ctx         = {req_cpu, req_thr};
  assign unused_low_bits = ^req_addr[GRAN_LSB-1:0];

  logic [N_ENTRIES-1:0] slot_vld;
  logic [CTX_W-1:0]     slot_ctx  [N_ENTRIES];
  logic [GRAN_W-1:0]    slot_gran [N_ENTRIES];
  logic [N_ENTRIES-1:0] ctx_hit, gran_hit, wr_en, clr, first_free, oldest, alloc_oh;

  logic is_lr, is_wr, is_sc, any_ctx, full, sc_pass;

  assign is_lr   = req_vld && (cmd == CMD_LR);
  assign is_sc   = req_vld && (cmd == CMD_SC);
  assign is_wr   = req_vld && (cmd == CMD_ST || cmd == CMD_SC);
  assign any_ctx = |ctx_hit;
  assign full    = &slot_vld;
  assign sc_pass = |(ctx_hit & gran_hit);

  always_comb begin
    logic found;
    found      = 1'b0;
    first_free = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (!slot_vld[i] && !found) begin
        first_free[i] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  assign alloc_oh = (is_lr && !any_ctx) ? (full ? oldest : first_free) : '0;
  assign wr_en    = (is_lr && any_ctx) ? ctx_hit : alloc_oh;
  assign clr      = is_wr ? gran_hit : '0;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    assign ctx_hit[g]  = slot_vld[g] && (slot_ctx[g] == req_ctx);
    assign gran_hit[g] = slot_vld[g] && (slot_gran[g] == req_gran);

    rsv_slot #(
      .CTX_W  (CTX_W),
      .GRAN_W (GRAN_W)
    ) i_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en[g]),
      .wr_ctx  (req_ctx),
      .wr_gran (req_gran),
      .clr     (clr[g]),
      .vld_o   (slot_vld[g]),
      .ctx_o   (slot_ctx[g]),
      .gran_o  (slot_gran[g])
    );
  end

  rsv_age #(.N(N_ENTRIES)) i_age (
    .clk       (clk),
    .rst       (rst),
    .alloc_oh  (alloc_oh),
    .vld       (slot_vld),
    .oldest_oh (oldest)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld   <= 1'b0;
      rsp_wr_ok <= 1'b0;
      rsp_sc_ok <= 1'b0;
    end else begin
      rsp_vld   <= req_vld;
      rsp_wr_ok <= (req_vld && cmd == CMD_ST) || (is_sc && sc_pass);
      rsp_sc_ok <= is_sc && sc_pass;
    end
  end

  AST_ONE_PER_CTX: assert property (@(posedge clk) disable iff (rst)
    $countones(ctx_hit) <= 1); // R2
  AST_STORE_PERMIT: assert property (@(posedge clk) disable iff (rst)
    (req_vld && cmd == CMD_ST) |=> (rsp_wr_ok && !rsp_sc_ok)); // R5
  AST_SC_GATES_WRITE: assert property (@(posedge clk) disable iff (rst)
    rsp_sc_ok |-> rsp_wr_ok); // R6
  AST_NO_HIT_NO_PASS: assert property (@(posedge clk) disable iff (rst)
    (is_sc && gran_hit == '0) |=> !rsp_sc_ok); // R6
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
    rsp_wr_ok |-> rsp_vld); // R9
endmodule

// File: tb/test_rsv_monitor.sv
module test_rsv_monitor;
  import rsv_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_vld = 1'b0;
  logic [1:0]  req_cmd = 2'd0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_cpu = '0;
  logic [0:0]  req_thr = '0;
  logic        rsp_vld, rsp_wr_ok, rsp_sc_ok;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  rsv_monitor i_rsv_monitor (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_cpu(req_cpu), .req_thr(req_thr),
    .rsp_vld(rsp_vld), .rsp_wr_ok(rsp_wr_ok), .rsp_sc_ok(rsp_sc_ok)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got wr_ok,sc_ok=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] cmd, input logic [31:0] addr,
                      input logic [1:0] cpu, input logic thr,
                      input logic ew, input logic es, input string tag);
    @(negedge clk);
    req_vld  = 1'b1;
    req_cmd  = cmd;
    req_addr = addr;
    req_cpu  = cpu;
    req_thr  = thr;
    exp_q.push_back({ew, es});
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = 1'b0;
    req_cmd = 2'd0;
  endtask

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (!rst && rsp_vld) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected response", 2'b11, 2'b00);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {rsp_wr_ok, rsp_sc_ok}, e);
      end
    end
  end

  // contexts: A=(0,0) B=(0,1) C=(1,0) D=(1,1) E=(2,0)
  task automatic stimulus();
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {rsp_vld, rsp_wr_ok}, 2'b00);
    check("R1 sc_ok in reset", {1'b0, rsp_sc_ok}, 2'b00);
    @(negedge clk); rst = 1'b0;

    send(CMD_SC, 32'h100, 2'd0, 1'b0, 0, 0, "R1 sc after reset fails");
    send(CMD_ST, 32'h100, 2'd0, 1'b0, 1, 0, "R5 plain store permitted");
    send(CMD_LR, 32'h100, 2'd0, 1'b0, 0, 0, "R10 lr response zero");
    send(CMD_SC, 32'h104, 2'd0, 1'b0, 1, 1, "R3 R9 sc same granule back to back");
    send(CMD_SC, 32'h100, 2'd0, 1'b0, 0, 0, "R4 own sc consumed reservation");

    send(CMD_LR, 32'h200, 2'd0, 1'b0, 0, 0, "R2 lr first");
    send(CMD_LR, 32'h300, 2'd0, 1'b0, 0, 0, "R2 lr overwrite");
    send(CMD_SC, 32'h200, 2'd0, 1'b0, 0, 0, "R2 old granule fails");
    send(CMD_SC, 32'h300, 2'd0, 1'b0, 1, 1, "R2 new granule succeeds");

    send(CMD_LR, 32'h400, 2'd0, 1'b0, 0, 0, "R4 lr A");
    send(CMD_LR, 32'h400, 2'd0, 1'b1, 0, 0, "R4 lr B shared");
    send(CMD_SC, 32'h400, 2'd0, 1'b1, 1, 1, "R4 R6 sc B succeeds");
    send(CMD_SC, 32'h400, 2'd0, 1'b0, 0, 0, "R4 sc A wiped by B");

    send(CMD_LR, 32'h500, 2'd0, 1'b0, 0, 0, "R4 lr A");
    send(CMD_LR, 32'h500, 2'd1, 1'b0, 0, 0, "R4 lr C");
    send(CMD_ST, 32'h507, 2'd0, 1'b1, 1, 0, "R5 store over reservations");
    send(CMD_SC, 32'h500, 2'd0, 1'b0, 0, 0, "R4 plain store cleared A");
    send(CMD_SC, 32'h500, 2'd1, 1'b0, 0, 0, "R4 plain store cleared C");

    send(CMD_LR, 32'h600, 2'd0, 1'b0, 0, 0, "R7 lr A");
    send(CMD_SC, 32'h600, 2'd0, 1'b1, 0, 0, "R6 other thread fails");
    send(CMD_SC, 32'h600, 2'd0, 1'b0, 0, 0, "R7 failed sc cleared A");

    send(CMD_LR,   32'h800, 2'd0, 1'b0, 0, 0, "R10 lr A");
    send(CMD_READ, 32'h800, 2'd0, 1'b0, 0, 0, "R10 read outputs zero");
    send(CMD_SC,   32'h800, 2'd0, 1'b0, 1, 1, "R10 read left reservation");

    send(CMD_LR, 32'h900, 2'd0, 1'b0, 0, 0, "R3 lr A");
    send(CMD_ST, 32'h908, 2'd0, 1'b0, 1, 0, "R3 neighbour store");
    send(CMD_SC, 32'h900, 2'd0, 1'b0, 1, 1, "R3 neighbour did not clear");
    idle();
    idle();

    send(CMD_LR, 32'hA00, 2'd0, 1'b0, 0, 0, "R8 fill A");
    send(CMD_LR, 32'hA10, 2'd0, 1'b1, 0, 0, "R8 fill B");
    send(CMD_LR, 32'hA20, 2'd1, 1'b0, 0, 0, "R8 fill C");
    send(CMD_LR, 32'hA30, 2'd1, 1'b1, 0, 0, "R8 fill D");
    send(CMD_LR, 32'hA40, 2'd2, 1'b0, 0, 0, "R8 E evicts");
    send(CMD_SC, 32'hA00, 2'd0, 1'b0, 0, 0, "R8 oldest A evicted");
    send(CMD_SC, 32'hA10, 2'd0, 1'b1, 1, 1, "R8 B kept");
    send(CMD_SC, 32'hA20, 2'd1, 1'b0, 1, 1, "R8 C kept");
    send(CMD_SC, 32'hA30, 2'd1, 1'b1, 1, 1, "R8 D kept");
    send(CMD_SC, 32'hA40, 2'd2, 1'b0, 1, 1, "R8 E present");

    send(CMD_LR, 32'hB00, 2'd0, 1'b0, 0, 0, "R8 fill A");
    send(CMD_LR, 32'hB10, 2'd0, 1'b1, 0, 0, "R8 fill B");
    send(CMD_LR, 32'hB20, 2'd1, 1'b0, 0, 0, "R8 fill C");
    send(CMD_LR, 32'hB30, 2'd1, 1'b1, 0, 0, "R8 fill D");
    send(CMD_ST, 32'hB00, 2'd3, 1'b0, 1, 0, "R5 store frees A");
    send(CMD_LR, 32'hB40, 2'd2, 1'b0, 0, 0, "R8 E takes free slot");
    send(CMD_LR, 32'hB50, 2'd0, 1'b0, 0, 0, "R8 A evicts oldest B");
    send(CMD_SC, 32'hB10, 2'd0, 1'b1, 0, 0, "R8 B evicted");
    send(CMD_SC, 32'hB20, 2'd1, 1'b0, 1, 1, "R8 C kept after free use");
    send(CMD_SC, 32'hB40, 2'd2, 1'b0, 1, 1, "R8 E kept");
    send(CMD_SC, 32'hB50, 2'd0, 1'b0, 1, 1, "R8 A present");
    idle();
    repeat (3) @(negedge clk);
    check("R9 all responses seen", {1'b0, exp_q.size() != 0}, 2'b00);
  endtask

  initial begin
    fork
      stimulus();
      begin
        repeat (20000) @(posedge clk);
        check("watchdog expired", 2'b11, 2'b00);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule